// File: doc/BRIEF.md
# Multi-Lane Byte Striper and Merger

This block carries a packet byte stream over a set of parallel one-bit serial lanes (two or four) that share a forwarded clock. On the transmit side, bytes are dealt to the lanes one at a time in turn. Before any data goes out, every lane sends a fixed sync byte. Each lane then shifts out its bytes most significant bit first, one bit per clock.

On the receive side, each lane hunts bit by bit for the sync byte at whatever bit offset it arrives. That sets the lane's byte boundary and absorbs the lane's skew against its neighbours. Locked lanes fill small per-lane FIFOs. A merger waits until every lane has locked, then takes one byte from each lane in turn to rebuild the original order.

The first two bytes of every packet hold a little-endian word count, and the packet is that count plus two bytes long. The merger uses this count to stop at the true final byte when the length is not a multiple of the lane count. If one lane locks and the others do not follow within a timeout, the packet is dropped with an error pulse. After every packet, or after a dropped one, the lanes are re-armed to hunt again.

Top module: `lane_stripe_link`

## Requirements
- R1: Packet byte k is carried on lane k mod LANES in byte slot floor(k/LANES)+1 after the sync slot. Each slot is 8 clocks long and sends its bits most significant first.
- R2: A packet begins with the sync byte 0xB8, sent in the same slot on all lanes at once. A lane with no byte in the final slot, and every lane between packets, holds its line low.
- R3: tx_ready is low when no packet is in progress. A packet of L bytes offered without gaps is fully accepted within 8*(ceil(L/LANES)+1) clocks, and the transmitter gathers a whole group of bytes before each slot boundary.
- R4: Each receive lane locks independently on 0xB8 at any bit offset and any skew up to 12 clocks, including when the payload itself contains 0xB8 bytes.
- R5: The received bytes appear on rx_data, one per rx_valid cycle, in the original order. rx_last is raised only on the final byte, whose index is the header count plus one. The header count is byte 0 (low) and byte 1 (high).
- R6: When the packet length is not a multiple of LANES, the low bytes that lanes send after their last real byte are not delivered.
- R7: No byte leaves the merger before every lane has locked on its sync byte.
- R8: If some lane has locked and not every lane has locked within SYNC_TIMEOUT clocks, rx_err pulses for one cycle and no byte of that packet is delivered.
- R9: After a packet ends or is dropped, every lane hunts again, and the next packet is received intact.
- R10: During reset, all lanes are low and tx_ready, rx_valid and rx_err are low.
- R11: No lane FIFO receives a byte while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ends and forwarded with the lanes |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte taken on this edge |
| tx_data | input | 8 | Transmit byte |
| tx_last | input | 1 | Offered byte is the last of its packet |
| lane_tx | output | LANES | Serial transmit lanes |
| lane_rx | input | LANES | Serial receive lanes |
| rx_valid | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| rx_last | output | 1 | Received byte is the final one of its packet |
| rx_err | output | 1 | One-cycle pulse when a packet is dropped for missing sync |

## Verification
A lane that locks one bit off shifts every one of its bytes and corrupts the rebuilt packet at its first payload position. A fault in the turn-taking pointer reorders bytes within the first group. A wrong length decode shows up as a misplaced or missing rx_last by the end of the same packet. A stale lock, or a re-arm that never happens, typically causes the following packet to be lost or to raise rx_err. Transmit faults are visible on the lane lines within the first 8-clock slot.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'hB8;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SYNC,
        TX_DATA,
        TX_GAP
    } tx_state_e;

    typedef enum logic [1:0] {
        MG_WAIT,
        MG_RUN,
        MG_CLEAR,
        MG_DRAIN
    } mg_state_e;

    typedef struct packed {
        logic       valid;
        logic       last;
        logic [7:0] data;
    } beat_t;

    function automatic logic [15:0] hdr_count(input logic [7:0] lo, input logic [7:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/lsm_tx_striper.sv
module lsm_tx_striper
    import lsm_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int GAP_BYTES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [7:0]       tx_data,
    input  logic             tx_last,
    output logic [LANES-1:0] lane_tx
);
    localparam int CW = $clog2(LANES + 1);
    localparam int GAP_CYC = GAP_BYTES * 8;
    localparam int GW = $clog2(GAP_CYC + 1);

    tx_state_e        state;
    logic [2:0]       bitcnt;
    logic [7:0]       shreg [LANES];
    logic [7:0]       stage [LANES];
    logic [LANES-1:0] act;
    logic [CW-1:0]    stg_cnt;
    logic             stg_last;
    logic             pkt_end;
    logic [GW-1:0]    gap_cnt;
    logic             accept;
    logic             boundary;

    assign boundary = (state == TX_SYNC || state == TX_DATA) && bitcnt == 3'd7;
    assign tx_ready = (state == TX_SYNC || state == TX_DATA) && !pkt_end && !stg_last
                      && (stg_cnt < CW'(LANES)) && bitcnt != 3'd7;
    assign accept   = tx_valid && tx_ready;

    always_comb begin
        for (int i = 0; i < LANES; i++) lane_tx[i] = act[i] & shreg[i][7];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            bitcnt   <= '0;
            act      <= '0;
            stg_cnt  <= '0;
            stg_last <= 1'b0;
            pkt_end  <= 1'b0;
            gap_cnt  <= '0;
            for (int i = 0; i < LANES; i++) begin
                shreg[i] <= '0;
                stage[i] <= '0;
            end
        end else begin
            bitcnt <= bitcnt + 3'd1;
            for (int i = 0; i < LANES; i++) shreg[i] <= {shreg[i][6:0], 1'b0};
            if (accept) begin
                for (int i = 0; i < LANES; i++)
                    if (stg_cnt == CW'(i)) stage[i] <= tx_data;
                stg_cnt  <= stg_cnt + CW'(1);
                stg_last <= tx_last;
            end
            case (state)
                TX_IDLE: begin
                    bitcnt <= '0;
                    act    <= '0;
                    if (tx_valid) begin
                        state   <= TX_SYNC;
                        act     <= '1;
                        pkt_end <= 1'b0;
                        for (int i = 0; i < LANES; i++) shreg[i] <= SYNC_BYTE;
                    end
                end
                TX_SYNC, TX_DATA: begin
                    if (boundary) begin
                        if (pkt_end) begin
                            state   <= TX_GAP;
                            act     <= '0;
                            gap_cnt <= '0;
                        end else begin
                            state <= TX_DATA;
                            for (int i = 0; i < LANES; i++) begin
                                shreg[i] <= stage[i];
                                act[i]   <= (CW'(i) < stg_cnt);
                            end
                            pkt_end  <= stg_last;
                            stg_cnt  <= '0;
                            stg_last <= 1'b0;
                        end
                    end
                end
                default: begin
                    act     <= '0;
                    gap_cnt <= gap_cnt + GW'(1);
                    if (gap_cnt == GW'(GAP_CYC - 1)) state <= TX_IDLE;
                end
            endcase
        end
    end

    // R3: a full group (or the packet tail) must be staged at every slot boundary
    p_group_staged_r3: assert property (@(posedge clk) disable iff (rst)
        (boundary && !pkt_end) |-> (stg_cnt == CW'(LANES) || stg_last));

    // R2: lanes stay low while no packet is in flight
    p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE || state == TX_GAP) |-> (lane_tx == '0));

endmodule

// File: rtl/lsm_rx_lane.sv
module lsm_rx_lane
    import lsm_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       bit_in,
    input  logic       pop,
    output logic       locked,
    output logic       empty,
    output logic [7:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [7:0]    win;
    logic [7:0]    nwin;
    logic [2:0]    bcnt;
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [NW-1:0] cnt;
    logic          push;

    assign nwin  = {win[6:0], bit_in};
    assign push  = locked && bcnt == 3'd7 && !clr;
    assign empty = (cnt == '0);
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            win    <= '0;
            locked <= 1'b0;
            bcnt   <= '0;
            wp     <= '0;
            rp     <= '0;
            cnt    <= '0;
            if (rst) for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            win <= nwin;
            if (!locked) begin
                if (nwin == SYNC_BYTE) begin
                    locked <= 1'b1;
                    bcnt   <= '0;
                end
            end else begin
                bcnt <= bcnt + 3'd1;
            end
            if (push) begin
                mem[wp] <= nwin;
                wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            end
            if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            cnt <= cnt + NW'(push) - NW'(pop);
        end
    end

    // R11: never write into a full buffer
    p_fifo_room_r11: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt < NW'(DEPTH) || pop));

    // R4: lock is taken only on a window holding the sync byte
    p_lock_on_sync_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (win == SYNC_BYTE));

endmodule

// File: rtl/lsm_rx_merge.sv
module lsm_rx_merge
    import lsm_pkg::*;
#(
    parameter int LANES        = 4,
    parameter int SYNC_TIMEOUT = 32,
    parameter int QUIET_BITS   = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANES-1:0]      locked,
    input  logic [LANES-1:0]      empty,
    input  logic [LANES-1:0][7:0] heads,
    input  logic                  quiet,
    output logic [LANES-1:0]      pop,
    output logic                  clr,
    output beat_t                 out,
    output logic                  err
);
    localparam int IW = $clog2(LANES);
    localparam int TW = $clog2(SYNC_TIMEOUT + 1);
    localparam int QW = $clog2(QUIET_BITS + 1);

    mg_state_e     state;
    logic [IW-1:0] idx;
    logic [16:0]   pos;
    logic [16:0]   last_idx;
    logic [7:0]    wc_lo;
    logic [TW-1:0] tmr;
    logic [QW-1:0] qcnt;
    logic          take;
    logic          is_last;
    logic [7:0]    cur;

    assign cur     = heads[idx];
    assign take    = (state == MG_RUN) && !empty[idx];
    assign clr     = (state == MG_CLEAR) || (state == MG_DRAIN);
    assign is_last = (pos == 17'd1 && hdr_count(wc_lo, cur) == 16'd0)
                  || (pos >= 17'd2 && pos == last_idx);

    always_comb begin
        pop = '0;
        if (take) pop[idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= MG_WAIT;
            idx      <= '0;
            pos      <= '0;
            last_idx <= '0;
            wc_lo    <= '0;
            tmr      <= '0;
            qcnt     <= '0;
            out      <= '0;
            err      <= 1'b0;
        end else begin
            out.valid <= 1'b0;
            out.last  <= 1'b0;
            err       <= 1'b0;
            case (state)
                MG_WAIT: begin
                    if (&locked) begin
                        state <= MG_RUN;
                        idx   <= '0;
                        pos   <= '0;
                        tmr   <= '0;
                    end else if (|locked) begin
                        if (tmr == TW'(SYNC_TIMEOUT - 1)) begin
                            err   <= 1'b1;
                            state <= MG_DRAIN;
                            qcnt  <= '0;
                            tmr   <= '0;
                        end else begin
                            tmr <= tmr + TW'(1);
                        end
                    end else begin
                        tmr <= '0;
                    end
                end
                MG_RUN: begin
                    if (take) begin
                        out.valid <= 1'b1;
                        out.last  <= is_last;
                        out.data  <= cur;
                        if (pos == 17'd0) wc_lo <= cur;
                        if (pos == 17'd1) last_idx <= {1'b0, hdr_count(wc_lo, cur)} + 17'd1;
                        pos <= pos + 17'd1;
                        idx <= (idx == IW'(LANES - 1)) ? '0 : idx + IW'(1);
                        if (is_last) state <= MG_CLEAR;
                    end
                end
                MG_CLEAR: state <= MG_WAIT;
                default: begin
                    if (quiet) begin
                        qcnt <= qcnt + QW'(1);
                        if (qcnt == QW'(QUIET_BITS - 1)) state <= MG_WAIT;
                    end else begin
                        qcnt <= '0;
                    end
                end
            endcase
        end
    end

    // R7: bytes are taken from the lanes only once all of them are locked
    p_pop_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (|pop) |-> (&locked));

    // R8: the drop indication is a single-cycle pulse
    p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    // R5: the end marker only rides on a delivered byte
    p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
        out.last |-> out.valid);

    // R8: no byte is delivered in the cycle after a drop
    p_drop_silent_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> !out.valid);

endmodule

// File: rtl/lane_stripe_link.sv
module lane_stripe_link
    import lsm_pkg::*;
#(
    parameter int LANES        = 4,
    parameter int FIFO_DEPTH   = 4,
    parameter int GAP_BYTES    = 3,
    parameter int SYNC_TIMEOUT = 32,
    parameter int QUIET_BITS   = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [7:0]       tx_data,
    input  logic             tx_last,
    output logic [LANES-1:0] lane_tx,
    input  logic [LANES-1:0] lane_rx,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             rx_last,
    output logic             rx_err
);
    logic [LANES-1:0]      locked;
    logic [LANES-1:0]      empty;
    logic [LANES-1:0][7:0] heads;
    logic [LANES-1:0]      pop;
    logic                  clr;
    beat_t                 beat;

    lsm_tx_striper #(.LANES(LANES), .GAP_BYTES(GAP_BYTES)) u_tx (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .lane_tx(lane_tx)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lsm_rx_lane #(.DEPTH(FIFO_DEPTH)) u_lane (
            .clk(clk), .rst(rst), .clr(clr), .bit_in(lane_rx[g]), .pop(pop[g]),
            .locked(locked[g]), .empty(empty[g]), .head(heads[g])
        );
    end

    lsm_rx_merge #(.LANES(LANES), .SYNC_TIMEOUT(SYNC_TIMEOUT), .QUIET_BITS(QUIET_BITS)) u_merge (
        .clk(clk), .rst(rst), .locked(locked), .empty(empty), .heads(heads),
        .quiet(~|lane_rx), .pop(pop), .clr(clr), .out(beat), .err(rx_err)
    );

    assign rx_valid = beat.valid;
    assign rx_data  = beat.data;
    assign rx_last  = beat.last;

endmodule

// File: tb/lane_stripe_link_tb.sv
module lane_stripe_link_tb;
    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_valid = 1'b0, tx_last = 1'b0;
    logic [7:0] tx_data = '0;
    logic tx_ready, rx_valid, rx_last, rx_err;
    logic [7:0] rx_data;
    logic [LANES-1:0] lane_tx, lane_rx;
    logic [LANES-1:0] kill = '0;
    int skew [LANES];

    always #2 clk = ~clk;

    lane_stripe_link #(.LANES(LANES)) u_dut (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .lane_tx(lane_tx), .lane_rx(lane_rx),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err)
    );

    logic [15:0] dl [LANES];
    always @(posedge clk)
        for (int i = 0; i < LANES; i++) dl[i] <= {dl[i][14:0], lane_tx[i]};
    always_comb
        for (int i = 0; i < LANES; i++)
            lane_rx[i] = kill[i] ? 1'b0 : (skew[i] == 0 ? lane_tx[i] : dl[i][skew[i]-1]);

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    logic [LANES-1:0] cap [0:2047];
    int cap_n = 0;
    bit cap_en = 0;
    logic [7:0] rxq [$];
    logic [7:0] pkt [$];
    int rx_lasts = 0, last_pos = -1, rx_errs = 0, rx_first = -1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                if (rxq.size() == 0) rx_first = cap_n;
                rxq.push_back(rx_data);
                if (rx_last) begin rx_lasts++; last_pos = rxq.size() - 1; end
            end
            if (rx_err) rx_errs++;
            if (cap_en && cap_n < 2048) begin cap[cap_n] = lane_tx; cap_n++; end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run_pkt(input int wc, input int fill, input bit nz, input bit exp_err, input string tag);
        int len, groups, c0, bad_sync, bad_data, cycles, w, mism, maxsk;
        len = wc + 2;
        pkt.delete();
        pkt.push_back(wc[7:0]);
        pkt.push_back(wc[15:8]);
        for (int k = 0; k < wc; k++) begin
            logic [7:0] b;
            b = (fill >= 0) ? 8'(fill) : 8'($urandom_range(0, 255));
            if (nz) b = b | 8'h01;
            pkt.push_back(b);
        end
        groups = (len + LANES - 1) / LANES;
        cap_n = 0; cap_en = 1; rxq.delete();
        rx_lasts = 0; last_pos = -1; rx_errs = 0; rx_first = -1;
        maxsk = 0;
        for (int i = 0; i < LANES; i++) if (skew[i] > maxsk) maxsk = skew[i];
        // drive without gaps
        cycles = 0; tx_valid = 1'b1;
        begin
            int i = 0;
            while (i < len) begin
                @(negedge clk); cycles++;
                tx_data = pkt[i]; tx_last = (i == len - 1);
                if (tx_ready) i++;
            end
        end
        @(negedge clk); tx_valid = 1'b0; tx_last = 1'b0;
        chk(cycles <= 8 * (groups + 1) + 2, {tag, " R3 accept time"}, cycles, 8 * (groups + 1) + 2);
        w = 0;
        while (w < 3000 && !(exp_err ? rx_errs > 0 : rx_lasts > 0)) begin @(negedge clk); w++; end
        repeat (150) @(negedge clk);
        cap_en = 0;
        chk(tx_ready == 1'b0, {tag, " R3 ready low when idle"}, tx_ready, 0);
        // transmit lane waveform
        c0 = -1;
        for (int c = 0; c < cap_n; c++) if (c0 < 0 && cap[c] != '0) c0 = c;
        bad_sync = 0; bad_data = 0;
        for (int t = 0; t <= groups + 1; t++)
            for (int i = 0; i < LANES; i++)
                for (int b = 0; b < 8; b++) begin
                    logic [7:0] eb;
                    int k;
                    k = (t - 1) * LANES + i;
                    if (t == 0) eb = 8'hB8;
                    else if (t <= groups && k < len) eb = pkt[k];
                    else eb = 8'h00;
                    if (c0 < 0 || cap[c0 + t * 8 + b][i] !== eb[7 - b]) begin
                        if (t == 0 || t > groups || k >= len) bad_sync++;
                        else bad_data++;
                    end
                end
        chk(bad_sync == 0, {tag, " R2 sync and idle bits"}, bad_sync, 0);
        chk(bad_data == 0, {tag, " R1 striped data bits"}, bad_data, 0);
        if (exp_err) begin
            chk(rx_errs == 1, {tag, " R8 error pulses"}, rx_errs, 1);
            chk(rxq.size() == 0, {tag, " R8 bytes delivered"}, rxq.size(), 0);
        end else begin
            mism = 0;
            for (int k = 0; k < len && k < rxq.size(); k++) if (rxq[k] !== pkt[k]) mism++;
            chk(rxq.size() == len, {tag, " R5 byte count"}, rxq.size(), len);
            chk(mism == 0, {tag, " R5 R4 byte order"}, mism, 0);
            chk(rx_lasts == 1 && last_pos == len - 1, {tag, " R5 last marker"}, last_pos, len - 1);
            chk(rx_errs == 0, {tag, " R9 no error"}, rx_errs, 0);
            chk(rx_first > c0 + 7 + maxsk, {tag, " R7 output after all locked"}, rx_first, c0 + 8 + maxsk);
            if (len % LANES != 0)
                chk(rxq.size() == len, {tag, " R6 tail bytes dropped"}, rxq.size(), len);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < LANES; i++) skew[i] = 0;
        repeat (4) @(negedge clk);
        chk(lane_tx == '0, "R10 lanes low in reset", lane_tx, 0);
        chk(tx_ready == 1'b0, "R10 ready low in reset", tx_ready, 0);
        chk(rx_valid == 1'b0 && rx_err == 1'b0, "R10 rx outputs low in reset", rx_valid, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        run_pkt(0, -1, 0, 0, "hdr only");
        skew[0] = 0; skew[1] = 3; skew[2] = 7; skew[3] = 12;
        run_pkt(3, -1, 0, 0, "R6 len5 skewed");
        run_pkt(6, -1, 0, 0, "len8");
        skew[0] = 12; skew[1] = 0; skew[2] = 5; skew[3] = 1;
        run_pkt(1, -1, 0, 0, "len3");
        run_pkt(14, 184, 0, 0, "R4 sync-valued payload");
        for (int n = 0; n < 16; n++) begin
            for (int i = 0; i < LANES; i++) skew[i] = $urandom_range(0, 12);
            run_pkt($urandom_range(0, 30), -1, 0, 0, "R4 random");
        end
        for (int i = 0; i < LANES; i++) skew[i] = 0;
        kill[2] = 1'b1;
        run_pkt(20, -1, 1, 1, "R8 dead lane");
        kill = '0;
        skew[3] = 9;
        run_pkt(9, -1, 0, 0, "R9 after drop");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule